// File: doc/BRIEF.md
# Variable-Length Vector Loop Sequencer

This block steps a vector loop through an array whose size need not be a whole number of hardware vectors. A start pulse delivers three things: the array's base address, the number of elements, and a code for the element size. The block then emits one descriptor per loop iteration. Each descriptor holds a byte address, an active length in bytes and a flag that marks the final iteration. Descriptors leave through a valid/ready handshake, so a vector data path can take one full vector on every clock. The block does no memory access itself.

Internally the loop runs on a signed byte index. At start the index is the negated array size, and it rises towards zero. Every address is formed as the array end plus the index. Every iteration before the last is a full vector. The final iteration shrinks on its own to the bytes that are left, so software needs no separate tail loop. The maximum vector length is fixed when the block is built, and the block drives it on a port so that software reads it instead of assuming it. The length travels with each descriptor because it changes during the loop.

Top module: `vl_loop_sequencer`

## Requirements
- R1: After reset, vec_valid_o, done_o and busy_o are all 0.
- R2: max_len_o always equals the parameter MAX_VL_BYTES (64 by default).
- R3: Every descriptor whose vec_last_o is 0 has vec_len_o equal to MAX_VL_BYTES.
- R4: The final descriptor of a loop is the only one with vec_last_o set. Its vec_len_o equals the total byte count minus MAX_VL_BYTES times the number of earlier descriptors, and lies between 1 and MAX_VL_BYTES.
- R5: The first descriptor's address is the base address. Each later address is the previous address plus the previous length, i.e. end of array plus the negative byte index.
- R6: A start with an element count of zero produces no descriptor, and done_o is 1 for exactly the cycle after the start edge.
- R7: done_o is 1 for exactly one cycle, the cycle after the edge at which the final descriptor is accepted (vec_valid_o and vec_ready_i both 1), and is 0 while descriptors remain.
- R8: While vec_valid_o is 1 and vec_ready_i is 0, the address, length and last flag hold their values and vec_valid_o stays 1.
- R9: With vec_ready_i held at 1, a new descriptor is presented on every cycle from the cycle after start until the final one is accepted.
- R10: A start pulse while busy_o is 1 is ignored. The loop in progress continues unchanged and no second loop follows it.
- R11: elem_size_i code k (0 to 3) means elements of 2^k bytes. The lengths of a loop sum to elem_count_i shifted left by k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a loop when the block is idle |
| base_addr_i | input | ADDR_W | Byte address of the first array element |
| elem_count_i | input | CNT_W | Number of array elements |
| elem_size_i | input | 2 | log2 of the element size in bytes |
| vec_ready_i | input | 1 | Consumer accepts the current descriptor |
| vec_valid_o | output | 1 | A descriptor is presented |
| vec_addr_o | output | ADDR_W | Byte address of this iteration |
| vec_len_o | output | LEN_W | Active length of this iteration in bytes |
| vec_last_o | output | 1 | Marks the final iteration |
| done_o | output | 1 | One-cycle pulse when a loop completes |
| busy_o | output | 1 | A loop is in progress |
| max_len_o | output | LEN_W | Implementation's maximum vector length in bytes |

## Verification
The assertions watch several things on every cycle. Held descriptors must stay stable under back-pressure, and no descriptor may be empty or longer than the maximum. A non-final descriptor must be full length. Each accepted non-final beat must be followed by one whose address has advanced by the accepted length. An accepted final beat must produce a single done pulse. Only the bench's scenarios show the whole loop from end to end: that the final length is the correct remainder for each element size, that the lengths add up to the array size, that a zero-length array skips straight to done, and that a start issued mid-loop leaves the loop undisturbed.

// File: rtl/vls_pkg.sv
package vls_pkg;
   typedef enum logic {
      VLS_IDLE = 1'b0,
      VLS_RUN  = 1'b1
   } vls_state_e;

   localparam int unsigned VLS_ESZ_W   = 2;
   localparam int unsigned VLS_MAX_ESZ = 3;

   function automatic int unsigned vls_log2(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < v) r++;
      return r;
   endfunction

   function automatic bit vls_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/vls_setup.sv
module vls_setup
   import vls_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 16,
   localparam int unsigned TOT_W = CNT_W + VLS_MAX_ESZ
) (
   input  logic [ADDR_W-1:0]    base_addr,
   input  logic [CNT_W-1:0]     elem_count,
   input  logic [VLS_ESZ_W-1:0] elem_size,
   output logic [TOT_W-1:0]     total_bytes,
   output logic [ADDR_W-1:0]    end_addr
);
   logic [TOT_W-1:0] count_wide;

   always_comb begin
      count_wide  = TOT_W'(elem_count);
      total_bytes = count_wide << elem_size;
      end_addr    = base_addr + ADDR_W'(total_bytes);
   end
endmodule

// File: rtl/vls_len_calc.sv
module vls_len_calc
   import vls_pkg::*;
#(
   parameter int unsigned IDX_W        = 20,
   parameter int unsigned MAX_VL_BYTES = 64,
   parameter bit          LAST_BY_BITS = 1'b1,
   localparam int unsigned LOG_MAX     = vls_log2(MAX_VL_BYTES),
   localparam int unsigned LEN_W       = LOG_MAX + 1
) (
   input  logic [IDX_W-1:0] idx,
   output logic [LEN_W-1:0] len,
   output logic             last
);
   logic [IDX_W-1:0] remain;
   logic             fits;

   always_comb remain = IDX_W'(0) - idx;

   generate
      if (LAST_BY_BITS) begin : g_last_bits
         logic [IDX_W-LOG_MAX-1:0] upper;
         logic [LOG_MAX-1:0]       lower;
         always_comb begin
            upper = remain[IDX_W-1:LOG_MAX];
            lower = remain[LOG_MAX-1:0];
            fits  = (upper == '0) ||
                    ((upper == (IDX_W-LOG_MAX)'(1)) && (lower == '0));
         end
      end else begin : g_last_cmp
         always_comb fits = (remain <= IDX_W'(MAX_VL_BYTES));
      end
   endgenerate

   always_comb begin
      last = fits;
      len  = fits ? remain[LEN_W-1:0] : LEN_W'(MAX_VL_BYTES);
   end
endmodule

// File: rtl/vls_iter_ctrl.sv
module vls_iter_ctrl
   import vls_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned TOT_W        = 19,
   parameter int unsigned MAX_VL_BYTES = 64,
   localparam int unsigned IDX_W       = TOT_W + 1,
   localparam int unsigned LEN_W       = vls_log2(MAX_VL_BYTES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [TOT_W-1:0]  total_bytes,
   input  logic [ADDR_W-1:0] end_addr_in,
   input  logic [LEN_W-1:0]  cur_len,
   input  logic              cur_last,
   input  logic              ready,
   output logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] end_addr,
   output logic              running,
   output logic              done
);
   vls_state_e state_q;
   logic       accept;

   always_comb begin
      running = (state_q == VLS_RUN);
      accept  = running && ready;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= VLS_IDLE;
         idx      <= '0;
         end_addr <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            VLS_IDLE: begin
               if (start) begin
                  end_addr <= end_addr_in;
                  idx      <= IDX_W'(0) - {1'b0, total_bytes};
                  if (total_bytes == '0) done <= 1'b1;
                  else                   state_q <= VLS_RUN;
               end
            end
            VLS_RUN: begin
               if (accept) begin
                  if (cur_last) begin
                     state_q <= VLS_IDLE;
                     done    <= 1'b1;
                  end else begin
                     idx <= idx + IDX_W'(cur_len);
                  end
               end
            end
            default: state_q <= VLS_IDLE;
         endcase
      end
   end

   AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cur_len != '0) && (cur_len <= LEN_W'(MAX_VL_BYTES))); // R4
   AST_FULL_UNLESS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !cur_last) |-> (cur_len == LEN_W'(MAX_VL_BYTES))); // R3
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cur_last) |=> (done && !running)); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (running && start && !accept) |=> ($stable(idx) && $stable(end_addr))); // R10
endmodule

// File: rtl/vl_loop_sequencer.sv
module vl_loop_sequencer
   import vls_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned MAX_VL_BYTES = 64,
   parameter bit          LAST_BY_BITS = 1'b1,
   localparam int unsigned TOT_W       = CNT_W + VLS_MAX_ESZ,
   localparam int unsigned IDX_W       = TOT_W + 1,
   localparam int unsigned LEN_W       = vls_log2(MAX_VL_BYTES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic [CNT_W-1:0]  elem_count_i,
   input  logic [1:0]        elem_size_i,
   input  logic              vec_ready_i,
   output logic              vec_valid_o,
   output logic [ADDR_W-1:0] vec_addr_o,
   output logic [LEN_W-1:0]  vec_len_o,
   output logic              vec_last_o,
   output logic              done_o,
   output logic              busy_o,
   output logic [LEN_W-1:0]  max_len_o
);
   generate
      if (!vls_is_pow2(MAX_VL_BYTES) || MAX_VL_BYTES < 8) begin : g_bad_max
         $error("MAX_VL_BYTES must be a power of two of at least 8");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("ADDR_W must exceed the byte index width");
      end
      if (IDX_W <= LEN_W) begin : g_bad_cnt
         $error("CNT_W too small for MAX_VL_BYTES");
      end
   endgenerate

   logic [TOT_W-1:0]  total_bytes;
   logic [ADDR_W-1:0] end_in;
   logic [ADDR_W-1:0] end_q;
   logic [IDX_W-1:0]  idx;
   logic [LEN_W-1:0]  cur_len;
   logic              cur_last;
   logic              running;
   logic              done;

   vls_setup #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_setup (
      .base_addr   (base_addr_i),
      .elem_count  (elem_count_i),
      .elem_size   (elem_size_i),
      .total_bytes (total_bytes),
      .end_addr    (end_in)
   );

   vls_len_calc #(.IDX_W(IDX_W), .MAX_VL_BYTES(MAX_VL_BYTES),
                  .LAST_BY_BITS(LAST_BY_BITS)) u_len (
      .idx  (idx),
      .len  (cur_len),
      .last (cur_last)
   );

   vls_iter_ctrl #(.ADDR_W(ADDR_W), .TOT_W(TOT_W),
                   .MAX_VL_BYTES(MAX_VL_BYTES)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start_i),
      .total_bytes (total_bytes),
      .end_addr_in (end_in),
      .cur_len     (cur_len),
      .cur_last    (cur_last),
      .ready       (vec_ready_i),
      .idx         (idx),
      .end_addr    (end_q),
      .running     (running),
      .done        (done)
   );

   always_comb begin
      vec_valid_o = running;
      vec_addr_o  = end_q + {{(ADDR_W-IDX_W){idx[IDX_W-1]}}, idx};
      vec_len_o   = cur_len;
      vec_last_o  = running && cur_last;
      done_o      = done;
      busy_o      = running;
      max_len_o   = LEN_W'(MAX_VL_BYTES);
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid_o && !vec_ready_i) |=> (vec_valid_o && $stable(vec_addr_o)
         && $stable(vec_len_o) && $stable(vec_last_o))); // R8
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid_o && vec_ready_i && !vec_last_o) |=> (vec_valid_o &&
         (vec_addr_o == $past(vec_addr_o) + ADDR_W'($past(vec_len_o))))); // R5
   AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid_o && vec_ready_i && !vec_last_o) |=> vec_valid_o); // R9
   AST_MAX_CONST: assert property (@(posedge clk) disable iff (!rst_n)
      max_len_o == LEN_W'(MAX_VL_BYTES)); // R2
endmodule

// File: tb/tb_vl_loop_sequencer.sv
module tb_vl_loop_sequencer;
   localparam int MAXV = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] base_addr_i = '0;
   logic [15:0] elem_count_i = '0;
   logic [1:0]  elem_size_i = '0;
   logic        vec_ready_i = 1'b0;
   logic        vec_valid_o;
   logic [31:0] vec_addr_o;
   logic [6:0]  vec_len_o;
   logic        vec_last_o;
   logic        done_o;
   logic        busy_o;
   logic [6:0]  max_len_o;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   vl_loop_sequencer dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
      .elem_count_i(elem_count_i), .elem_size_i(elem_size_i),
      .vec_ready_i(vec_ready_i), .vec_valid_o(vec_valid_o),
      .vec_addr_o(vec_addr_o), .vec_len_o(vec_len_o), .vec_last_o(vec_last_o),
      .done_o(done_o), .busy_o(busy_o), .max_len_o(max_len_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_len(input int remain);
      return (remain > MAXV) ? MAXV : remain;
   endfunction

   task automatic run_case(input logic [31:0] b, input int cnt, input int esz,
                           input int rdy_pct, input bit poke_start);
      int  total, consumed, guard;
      bit  fin, was_stall;
      logic [31:0] p_addr;
      logic [6:0]  p_len;
      logic        p_last;
      total = cnt << esz;
      consumed = 0; fin = 0; was_stall = 0; guard = 0;
      p_addr = '0; p_len = '0; p_last = 1'b0;
      @(negedge clk);
      start_i = 1'b1; base_addr_i = b; elem_count_i = 16'(cnt);
      elem_size_i = 2'(esz); vec_ready_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      if (total == 0) begin
         check(done_o === 1'b1, "R6", "done on empty", done_o, 1);
         check(vec_valid_o === 1'b0, "R6", "valid on empty", vec_valid_o, 0);
         @(negedge clk);
         check(done_o === 1'b0 && vec_valid_o === 1'b0, "R6", "after empty",
               {done_o, vec_valid_o}, 0);
         return;
      end
      while (!fin && guard < 5000) begin
         guard++;
         check(vec_valid_o === 1'b1, (rdy_pct == 100) ? "R9" : "R8", "valid",
               vec_valid_o, 1);
         check(done_o === 1'b0, "R7", "early done", done_o, 0);
         check(vec_addr_o === b + 32'(consumed), "R5", "addr", vec_addr_o,
               b + 32'(consumed));
         check(int'(vec_len_o) == exp_len(total - consumed),
               (total - consumed > MAXV) ? "R3" : "R4", "len", vec_len_o,
               exp_len(total - consumed));
         check(vec_last_o === (total - consumed <= MAXV), "R4", "last",
               vec_last_o, (total - consumed <= MAXV));
         if (was_stall)
            check(vec_addr_o === p_addr && vec_len_o === p_len &&
                  vec_last_o === p_last, "R8", "hold", vec_addr_o, p_addr);
         p_addr = vec_addr_o; p_len = vec_len_o; p_last = vec_last_o;
         vec_ready_i = (($urandom % 100) < 32'(rdy_pct));
         if (poke_start && ($urandom % 3 == 0)) begin
            start_i = 1'b1; base_addr_i = 32'hDEAD0000;
            elem_count_i = 16'd7; elem_size_i = 2'd1;
         end else begin
            start_i = 1'b0;
         end
         was_stall = !vec_ready_i;
         @(negedge clk);
         start_i = 1'b0;
         if (!was_stall) begin
            consumed += int'(p_len);
            if (p_last) fin = 1;
         end
      end
      vec_ready_i = 1'b0;
      check(done_o === 1'b1 && vec_valid_o === 1'b0, "R7", "done after last",
            {done_o, vec_valid_o}, 2);
      check(consumed == total, "R11", "sum of lengths", consumed, total);
      @(negedge clk);
      check(done_o === 1'b0, "R7", "done single", done_o, 0);
      check(vec_valid_o === 1'b0 && busy_o === 1'b0, "R10", "no extra loop",
            {vec_valid_o, busy_o}, 0);
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'd4242);
      #5;
      check(vec_valid_o === 1'b0 && done_o === 1'b0 && busy_o === 1'b0, "R1",
            "reset outputs", {vec_valid_o, done_o, busy_o}, 0);
      check(int'(max_len_o) == MAXV, "R2", "max length", max_len_o, MAXV);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check(vec_valid_o === 1'b0 && busy_o === 1'b0, "R1", "idle after reset",
            {vec_valid_o, busy_o}, 0);
      run_case(32'h0000_1000, 0, 2, 100, 0);       // R6
      run_case(32'h0000_2000, 32, 2, 100, 0);      // exact multiple, R3 R4
      run_case(32'h0000_3001, 1, 0, 100, 0);       // single byte
      run_case(32'h0001_0000, 100, 3, 100, 0);     // R11 eight-byte elements
      run_case(32'h0002_0000, 65, 0, 50, 0);       // R8 stalls
      run_case(32'h0003_0000, 40, 1, 70, 1);       // R10 start while busy
      run_case(32'hFFFF_FFC0, 20, 3, 100, 0);      // address wrap
      for (int i = 0; i < 24; i++)
         run_case($urandom, int'($urandom % 300), int'($urandom % 4),
                  30 + int'($urandom % 71), ($urandom % 2) == 1);
      check(int'(max_len_o) == MAXV, "R2", "max length end", max_len_o, MAXV);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule